// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a decoded write to a software-generated-interrupt register into pending state. Each write names an interrupt number, the processor that issued it, an eight-bit list of candidate targets and a two-bit filter that says how the target set is formed. The block resolves the final target set and drops any target whose processor interface is switched off. It then records one pending bit per (interrupt, source, target) triple. Because a bit is kept for each source, two processors raising the same interrupt at the same target stay distinguishable.

A processor interface counts as switched on when either of its two group-enable control bits is set. An acknowledge path clears a single pending bit, named by interrupt number, source and target. Whenever a write leaves at least one accepted target, the block raises a one-cycle request so that the surrounding interrupt logic re-evaluates its state. Choosing among pending interrupts happens elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is held and after it is released, every pending bit reads 0 and `upd_req` reads 0 until the first accepted write.
- R2: With filter code 0, the accepted targets are the processors whose bit is set in `wr_list` (bit t names processor t).
- R3: With filter code 1, `wr_list` is ignored and the accepted targets are all processors whose interface is currently switched on.
- R4: With filter code 2, the only candidate target is the requesting processor `wr_src`.
- R5: A processor's interface is switched on when `grp_en[2t]` (group 0) or `grp_en[2t+1]` (group 1) is 1. A candidate whose interface is off gets no pending bit.
- R6: An accepted write sets `pend[id*64 + src*8 + tgt]`, where the 64-bit slice for interrupt `id` holds bit (target + 8 × source). The new bit is visible one clock after the write cycle.
- R7: Filter code 3 is reserved: such a write changes no pending bit and raises no `upd_req`.
- R8: A clear with `clr_valid` high resets exactly the bit `pend[clr_id*64 + clr_src*8 + clr_tgt]` one clock later and leaves every other bit unchanged.
- R9: When a write sets the same bit that a clear names in the same cycle, the bit ends up set.
- R10: `upd_req` is 1 for the single cycle after a write cycle with at least one accepted target, and 0 after any other cycle.
- R11: Pending bits are sticky. Without a clear naming them they stay set across later writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Write strobe for one dispatch request |
| wr_src | input | 3 | Index of the requesting processor |
| wr_id | input | 4 | Interrupt number |
| wr_list | input | 8 | Candidate target list, bit t for processor t |
| wr_filter | input | 2 | Target filter: 0 list, 1 all enabled, 2 self, 3 reserved |
| grp_en | input | 16 | Two group-enable bits per processor, pair t at bits 2t and 2t+1 |
| clr_valid | input | 1 | Clear strobe for one pending bit |
| clr_id | input | 4 | Interrupt number of the bit to clear |
| clr_src | input | 3 | Source processor of the bit to clear |
| clr_tgt | input | 3 | Target processor of the bit to clear |
| pend | output | 1024 | Pending array, 16 slices of 64 bits |
| upd_req | output | 1 | One-cycle request to re-evaluate interrupt state |

## Verification
A dispatch write and an acknowledge clear can land in the same cycle. When both name the same pending bit, the result depends on which one is given precedence. The bench provokes this with a self-targeted write and a clear of that exact bit in one cycle, and expects the bit to read 1 afterwards. It also pairs writes with clears of neighbouring bits in the same cycle, where both effects must show. The bench's reference array applies the clear first and the set second, so every same-cycle combination in the sweep is judged against the required precedence.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  typedef enum logic [1:0] {
    FLT_LIST    = 2'd0,
    FLT_ENABLED = 2'd1,
    FLT_SELF    = 2'd2,
    FLT_RSVD    = 2'd3
  } sgi_filter_e;

endpackage

// File: rtl/sgi_rst_sync.sv
module sgi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sgi_cpu_enable.sv
module sgi_cpu_enable #(
  parameter int NCPU = 8
) (
  input  logic [2*NCPU-1:0] grp_en_i,
  output logic [NCPU-1:0]   if_en_o
);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign if_en_o[c] = grp_en_i[2*c] | grp_en_i[2*c+1];
  end

endmodule

// File: rtl/sgi_target_resolve.sv
module sgi_target_resolve
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  localparam int SRC_W = $clog2(NCPU)
) (
  input  logic [1:0]       filter_i,
  input  logic [NCPU-1:0]  list_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [NCPU-1:0]  if_en_i,
  output logic [NCPU-1:0]  accept_o
);

  sgi_filter_e     mode;
  logic [NCPU-1:0] self_mask;
  logic [NCPU-1:0] cand;

  assign mode = sgi_filter_e'(filter_i);

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      self_mask[i] = (src_i == SRC_W'(i));
    end
  end

  always_comb begin
    case (mode)
      FLT_LIST:    cand = list_i;
      FLT_ENABLED: cand = if_en_i;
      FLT_SELF:    cand = self_mask;
      default:     cand = '0;
    endcase
  end

  assign accept_o = cand & if_en_i;

endmodule

// File: rtl/sgi_pend_entry.sv
module sgi_pend_entry #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic         pend_en;

  always_comb begin
    pend_en = (|set_i) | (|clr_i);
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU   = 8,
  parameter int NUM_ID = 16,
  localparam int SRC_W  = $clog2(NCPU),
  localparam int ID_W   = $clog2(NUM_ID),
  localparam int ENT_W  = NCPU * NCPU,
  localparam int PEND_W = NUM_ID * ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [NCPU-1:0]   wr_list,
  input  logic [1:0]        wr_filter,
  input  logic [2*NCPU-1:0] grp_en,
  input  logic              clr_valid,
  input  logic [ID_W-1:0]   clr_id,
  input  logic [SRC_W-1:0]  clr_src,
  input  logic [SRC_W-1:0]  clr_tgt,
  output logic [PEND_W-1:0] pend,
  output logic              upd_req
);

  logic            rst_i_n;
  logic [NCPU-1:0] if_en;
  logic [NCPU-1:0] accept;
  logic [ENT_W-1:0] row_set;
  logic [ENT_W-1:0] row_clr;
  logic            upd_d;
  logic            upd_q;

  sgi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sgi_cpu_enable #(.NCPU(NCPU)) u_en (
    .grp_en_i (grp_en),
    .if_en_o  (if_en)
  );

  sgi_target_resolve #(.NCPU(NCPU)) u_res (
    .filter_i (wr_filter),
    .list_i   (wr_list),
    .src_i    (wr_src),
    .if_en_i  (if_en),
    .accept_o (accept)
  );

  // Place accepted targets in the row of the requesting source, and
  // decode the single bit named by the clear port.
  always_comb begin
    for (int s = 0; s < NCPU; s++) begin
      for (int t = 0; t < NCPU; t++) begin
        row_set[s*NCPU+t] = wr_valid && (wr_src == SRC_W'(s)) && accept[t];
        row_clr[s*NCPU+t] = clr_valid && (clr_src == SRC_W'(s)) &&
                            (clr_tgt == SRC_W'(t));
      end
    end
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_id
    logic [ENT_W-1:0] set_i;
    logic [ENT_W-1:0] clr_i;

    assign set_i = (wr_id  == ID_W'(i)) ? row_set : '0;
    assign clr_i = (clr_id == ID_W'(i)) ? row_clr : '0;

    sgi_pend_entry #(.W(ENT_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .set_i  (set_i),
      .clr_i  (clr_i),
      .pend_o (pend[i*ENT_W +: ENT_W])
    );
  end

  always_comb begin
    upd_d = wr_valid && (|accept);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  assign upd_req = upd_q;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU   = 8,
  parameter int NUM_ID = 16,
  localparam int SRC_W  = $clog2(NCPU),
  localparam int ID_W   = $clog2(NUM_ID),
  localparam int ENT_W  = NCPU * NCPU,
  localparam int PEND_W = NUM_ID * ENT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [SRC_W-1:0]  wr_src,
  input logic [ID_W-1:0]   wr_id,
  input logic [NCPU-1:0]   wr_list,
  input logic [1:0]        wr_filter,
  input logic [2*NCPU-1:0] grp_en,
  input logic              clr_valid,
  input logic [ID_W-1:0]   clr_id,
  input logic [SRC_W-1:0]  clr_src,
  input logic [SRC_W-1:0]  clr_tgt,
  input logic [PEND_W-1:0] pend,
  input logic              upd_req
);

  int   clr_idx;
  int   self_idx;
  logic src_on;

  assign clr_idx  = int'(clr_id) * ENT_W + int'(clr_src) * NCPU + int'(clr_tgt);
  assign self_idx = int'(wr_id) * ENT_W + int'(wr_src) * (NCPU + 1);
  assign src_on   = grp_en[2*int'(wr_src)] | grp_en[2*int'(wr_src)+1];

  AST_RSVD_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_filter == 2'd3 && !clr_valid) |=> $stable(pend)); // R7

  AST_RSVD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_filter == 2'd3) |=> !upd_req); // R7

  AST_IDLE_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !upd_req); // R10

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !wr_valid) |=> !pend[$past(clr_idx)]); // R8

  AST_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_filter == 2'd2 && src_on) |=> pend[$past(self_idx)]); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && clr_valid && wr_filter == 2'd2 && src_on &&
     clr_id == wr_id && clr_src == wr_src && clr_tgt == wr_src)
    |=> pend[$past(self_idx)]); // R9

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ((pend & ~$past(pend)) == '0)); // R11

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NUM_ID(NUM_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_src    (wr_src),
  .wr_id     (wr_id),
  .wr_list   (wr_list),
  .wr_filter (wr_filter),
  .grp_en    (grp_en),
  .clr_valid (clr_valid),
  .clr_id    (clr_id),
  .clr_src   (clr_src),
  .clr_tgt   (clr_tgt),
  .pend      (pend),
  .upd_req   (upd_req)
);

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;

  localparam int NCPU   = 8;
  localparam int NUM_ID = 16;
  localparam int ENT_W  = NCPU * NCPU;
  localparam int PEND_W = NUM_ID * ENT_W;
  localparam realtime TCLK = 20.0;

  logic              clk;
  logic              rst_n;
  logic              wr_valid;
  logic [2:0]        wr_src;
  logic [3:0]        wr_id;
  logic [7:0]        wr_list;
  logic [1:0]        wr_filter;
  logic [15:0]       grp_en;
  logic              clr_valid;
  logic [3:0]        clr_id;
  logic [2:0]        clr_src;
  logic [2:0]        clr_tgt;
  logic [PEND_W-1:0] pend;
  logic              upd_req;

  logic [PEND_W-1:0] exp_pend;
  logic              exp_upd;
  int                n_chk;
  int                n_bad;

  sgi_dispatch #(.NCPU(NCPU), .NUM_ID(NUM_ID)) i_sgi_dispatch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_src    (wr_src),
    .wr_id     (wr_id),
    .wr_list   (wr_list),
    .wr_filter (wr_filter),
    .grp_en    (grp_en),
    .clr_valid (clr_valid),
    .clr_id    (clr_id),
    .clr_src   (clr_src),
    .clr_tgt   (clr_tgt),
    .pend      (pend),
    .upd_req   (upd_req)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] model_accept(input logic [1:0] f, input logic [7:0] lst,
                                              input logic [2:0] s, input logic [15:0] en);
    logic [7:0] on;
    logic [7:0] cand;
    for (int c = 0; c < 8; c++) on[c] = en[2*c] | en[2*c+1];
    case (f)
      2'd0: cand = lst;
      2'd1: cand = on;
      2'd2: cand = 8'd1 << s;
      default: cand = 8'd0;
    endcase
    return cand & on;
  endfunction

  task automatic check_pend(input string tag);
    n_chk++;
    if (pend !== exp_pend) begin
      n_bad++;
      $display("FAIL %s pend actual=%h expected=%h", tag, pend, exp_pend);
    end
  endtask

  task automatic check_upd(input string tag);
    n_chk++;
    if (upd_req !== exp_upd) begin
      n_bad++;
      $display("FAIL %s upd_req actual=%b expected=%b", tag, upd_req, exp_upd);
    end
  endtask

  // Called at a falling edge; drives one cycle of stimulus, checks after the edge.
  task automatic step(input logic w, input logic [1:0] f, input logic [2:0] s,
                      input logic [3:0] id, input logic [7:0] lst, input logic [15:0] en,
                      input logic c, input logic [3:0] cid, input logic [2:0] cs,
                      input logic [2:0] ct, input string tag);
    logic [7:0] acc;
    wr_valid = w; wr_filter = f; wr_src = s; wr_id = id; wr_list = lst; grp_en = en;
    clr_valid = c; clr_id = cid; clr_src = cs; clr_tgt = ct;
    acc = w ? model_accept(f, lst, s, en) : 8'd0;
    if (c) exp_pend[int'(cid)*64 + int'(cs)*8 + int'(ct)] = 1'b0;
    for (int t = 0; t < 8; t++)
      if (acc[t]) exp_pend[int'(id)*64 + int'(s)*8 + t] = 1'b1;
    exp_upd = (acc != 8'd0);
    @(posedge clk);
    @(negedge clk);
    check_pend(tag);
    check_upd("R10");
    wr_valid = 1'b0; clr_valid = 1'b0;
  endtask

  initial begin
    #(TCLK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] en_pat [4];
    logic [7:0]  lst_pat [3];
    string       tg;
    n_chk = 0; n_bad = 0;
    exp_pend = '0; exp_upd = 1'b0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_filter = 2'd0; wr_src = '0; wr_id = '0;
    wr_list = '0; grp_en = '0; clr_valid = 1'b0; clr_id = '0; clr_src = '0; clr_tgt = '0;
    repeat (3) @(negedge clk);
    check_pend("R1"); check_upd("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pend("R1"); check_upd("R1");

    // R6: exact bit position for source 3, target 5, interrupt 9
    step(1'b1, 2'd0, 3'd3, 4'd9, 8'h20, 16'hFFFF, 1'b0, 4'd0, 3'd0, 3'd0, "R6");
    n_chk++;
    if (pend[9*64 + 3*8 + 5] !== 1'b1) begin
      n_bad++; $display("FAIL R6 pend[605] actual=%b expected=1", pend[9*64+29]);
    end

    // Sweep of filters, sources, lists and enable patterns (R2 R3 R4 R5 R7)
    en_pat[0] = 16'hFFFF; en_pat[1] = 16'hAAAA; en_pat[2] = 16'h0509; en_pat[3] = 16'h0000;
    lst_pat[0] = 8'hFF; lst_pat[1] = 8'h5A; lst_pat[2] = 8'h00;
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 4; f++)
        for (int l = 0; l < 3; l++)
          for (int e = 0; e < 4; e++) begin
            if (e >= 2 && f != 3) tg = "R5";
            else if (f == 0) tg = "R2";
            else if (f == 1) tg = "R3";
            else if (f == 2) tg = "R4";
            else tg = "R7";
            step(1'b1, 2'(f), 3'(s), 4'((s*3 + f + l*5 + e) % 16), lst_pat[l], en_pat[e],
                 1'b0, 4'd0, 3'd0, 3'd0, tg);
          end

    // R11: idle cycles keep everything
    for (int k = 0; k < 4; k++)
      step(1'b0, 2'd0, 3'd0, 4'd0, 8'h00, 16'hFFFF, 1'b0, 4'd0, 3'd0, 3'd0, "R11");

    // R9: set and clear of the same bit in one cycle, then neighbouring bits
    for (int s = 0; s < 8; s++) begin
      step(1'b1, 2'd2, 3'(s), 4'(s), 8'h00, 16'hFFFF,
           1'b1, 4'(s), 3'(s), 3'(s), "R9");
      step(1'b1, 2'd0, 3'(s), 4'(15 - s), 8'h81, 16'hFFFF,
           1'b1, 4'(15 - s), 3'(s), 3'((s + 1) % 8), "R9");
    end

    // R10: write with an empty accepted set raises no request
    step(1'b1, 2'd0, 3'd2, 4'd4, 8'hF0, 16'h00FF, 1'b0, 4'd0, 3'd0, 3'd0, "R10");

    // R8: clear every bit one at a time, alone on the port
    for (int i = 0; i < 16; i++)
      for (int s = 0; s < 8; s++)
        for (int t = 0; t < 8; t++)
          step(1'b0, 2'd0, 3'd0, 4'd0, 8'h00, 16'hFFFF,
               1'b1, 4'(i), 3'(s), 3'(t), "R8");
    n_chk++;
    if (pend !== '0) begin
      n_bad++; $display("FAIL R8 pend actual=%h expected=0", pend);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule